// File: doc/BRIEF.md
# Dual-Width Adder with Condition Flags

This block adds two integer operands and reports four condition flags: negative, zero, carry and overflow. A size input picks between a full 64-bit addition and a 32-bit addition on the low words. The second operand is either a register value or a short immediate. The immediate may be moved up by twelve bit positions, so that one instruction can build a larger constant.

The sum is combinational. It is valid in the same cycle as the operands, and the pipeline register that follows the block captures it. The condition flags live in a small register inside the block. A set-flags strobe decides whether an addition writes the flags. When the strobe is low, the flags keep the state left by the last flag-setting operation, so later conditional logic can read them.

Top module: `addflag_unit`

## Requirements
- R1: When `use_imm` is 1, the second operand is `imm_field` zero-extended, moved left by 12 positions when `imm_shift` is 1 and used as is when it is 0. When `use_imm` is 0, the second operand is `b_val`.
- R2: When `size64` is 1, `sum_out` is the sum of `a_val` and the second operand modulo 2^64, valid in the same cycle as the inputs.
- R3: When `size64` is 0, only bits 31:0 of both operands take part. `sum_out[31:0]` is their sum modulo 2^32 and `sum_out[63:32]` is zero.
- R4: The negative flag, `flags_out[3]`, takes the sign bit of the result at the active width: bit 63 for 64-bit operations, bit 31 for 32-bit operations.
- R5: The zero flag, `flags_out[2]`, is 1 exactly when the result at the active width is all zeros.
- R6: The carry flag, `flags_out[1]`, is 1 when the unsigned sum of the operands at the active width exceeds the largest value that width can hold.
- R7: The overflow flag, `flags_out[0]`, is 1 when both operands have the same sign at the active width and the result's sign differs from it.
- R8: The flags load the values from R4 to R7 at a rising clock edge only when `set_flags` is 1. Otherwise they keep their previous values.
- R9: While `rst` is 1 at a rising edge, the flags become 0000, even when `set_flags` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| size64 | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| use_imm | input | 1 | 1 takes the immediate as second operand |
| imm_field | input | 12 | Unsigned immediate |
| imm_shift | input | 1 | 1 moves the immediate left by 12 |
| a_val | input | 64 | First operand |
| b_val | input | 64 | Register second operand |
| set_flags | input | 1 | Write the flags at the next edge |
| sum_out | output | 64 | Sum, zero-extended for 32-bit operations |
| flags_out | output | 4 | Flag register {N, Z, C, V} |

## Verification
The assertions assume that every input is a known value and is held steady across each rising edge. They also assume that `set_flags` is meaningful in every cycle, because the block has no separate valid input. The stimulus changes all inputs together on the falling edge and drives a defined value on every port, including during reset. It checks the sum and the registered flags after the following rising edge. The stimulus covers directed cases at the carry and sign boundaries of both widths, with junk in the upper operand bits for 32-bit operations, and then a random mix of widths, operand sources and flag strobes.

// File: rtl/addflag_pkg.sv
package addflag_pkg;

    // Width of the flag register.
    localparam int FLAG_W = 4;

    // Operation width selected by the size input.
    typedef enum logic {
        OPW_32 = 1'b0,
        OPW_64 = 1'b1
    } opw_e;

    // Source of the second operand.
    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_IMM = 1'b1
    } src_e;

    // Condition flags, packed as {n, z, c, v}.
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam nzcv_t NZCV_CLEAR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    // Combine the flags of one lane from its msb inputs, result and carry out.
    function automatic nzcv_t lane_flags(input logic a_msb, input logic b_msb,
                                         input logic r_msb, input logic r_zero,
                                         input logic c_out);
        nzcv_t f;
        logic  c_into_msb;
        c_into_msb = r_msb ^ a_msb ^ b_msb;
        f.n = r_msb;
        f.z = r_zero;
        f.c = c_out;
        f.v = c_out ^ c_into_msb;
        return f;
    endfunction

endpackage

// File: rtl/addflag_opsel.sv
module addflag_opsel
    import addflag_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int IMM_W     = 12,
    parameter int IMM_SHIFT = 12
) (
    input  src_e              src_sel,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic              imm_shift,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] imm_final;

    always_comb begin
        imm_ext   = {{PAD_W{1'b0}}, imm_field};
        imm_final = imm_shift ? (imm_ext << IMM_SHIFT) : imm_ext;
    end

    always_comb begin
        unique case (src_sel)
            SRC_IMM: opnd_b = imm_final;
            default: opnd_b = reg_val;
        endcase
    end

endmodule

// File: rtl/addflag_lane.sv
module addflag_lane
    import addflag_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] lane_a,
    input  logic [W-1:0] lane_b,
    output logic [W-1:0] lane_sum,
    output nzcv_t        lane_nzcv
);
    logic [W:0] wide;

    always_comb begin
        wide      = {1'b0, lane_a} + {1'b0, lane_b};
        lane_sum  = wide[W-1:0];
        lane_nzcv = lane_flags(lane_a[W-1], lane_b[W-1], wide[W-1],
                               ~|wide[W-1:0], wide[W]);
    end

endmodule

// File: rtl/addflag_flagreg.sv
module addflag_flagreg
    import addflag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  nzcv_t next_flags,
    output nzcv_t cur_flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_flags <= NZCV_CLEAR;
        end else if (load) begin
            cur_flags <= next_flags;
        end
    end

endmodule

// File: rtl/addflag_unit.sv
module addflag_unit
    import addflag_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int IMM_W     = 12,
    parameter int IMM_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              size64,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic              imm_shift,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    input  logic              set_flags,
    output logic [DATA_W-1:0] sum_out,
    output logic [FLAG_W-1:0] flags_out
);
    localparam int HALF_W = DATA_W / 2;
    localparam int NUM_LANES = 2;

    opw_e              width_sel;
    src_e              src_sel;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] lane_sum [NUM_LANES];
    nzcv_t             lane_nz  [NUM_LANES];
    nzcv_t             next_flags;
    nzcv_t             cur_flags;

    assign width_sel = opw_e'(size64);
    assign src_sel   = src_e'(use_imm);

    addflag_opsel #(
        .DATA_W   (DATA_W),
        .IMM_W    (IMM_W),
        .IMM_SHIFT(IMM_SHIFT)
    ) u_opsel (
        .src_sel  (src_sel),
        .imm_field(imm_field),
        .imm_shift(imm_shift),
        .reg_val  (b_val),
        .opnd_b   (opnd_b)
    );

    // Lane 0 works on the low words, lane 1 on the full width.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF_W : DATA_W;
        logic [LW-1:0] part_sum;

        addflag_lane #(.W(LW)) u_lane (
            .lane_a   (a_val[LW-1:0]),
            .lane_b   (opnd_b[LW-1:0]),
            .lane_sum (part_sum),
            .lane_nzcv(lane_nz[g])
        );

        if (LW < DATA_W) begin : g_pad
            assign lane_sum[g] = {{(DATA_W-LW){1'b0}}, part_sum};
        end else begin : g_full
            assign lane_sum[g] = part_sum;
        end
    end

    always_comb begin
        unique case (width_sel)
            OPW_64: begin
                sum_out    = lane_sum[1];
                next_flags = lane_nz[1];
            end
            default: begin
                sum_out    = lane_sum[0];
                next_flags = lane_nz[0];
            end
        endcase
    end

    addflag_flagreg u_flagreg (
        .clk       (clk),
        .rst       (rst),
        .load      (set_flags),
        .next_flags(next_flags),
        .cur_flags (cur_flags)
    );

    assign flags_out = cur_flags;

endmodule

// File: rtl/addflag_unit_chk.sv
module addflag_unit_chk #(
    parameter int DATA_W    = 64,
    parameter int IMM_W     = 12,
    parameter int IMM_SHIFT = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              size64,
    input logic              use_imm,
    input logic [IMM_W-1:0]  imm_field,
    input logic              imm_shift,
    input logic [DATA_W-1:0] a_val,
    input logic              set_flags,
    input logic [DATA_W-1:0] sum_out,
    input logic [3:0]        flags_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] imm_up;
    assign imm_up = {{(DATA_W-IMM_W){1'b0}}, imm_field} << IMM_SHIFT;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> flags_out == 4'b0000); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable(flags_out)); // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        !size64 |-> sum_out[DATA_W-1:HALF_W] == '0); // R3

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (set_flags && size64) |=> flags_out[2] == ($past(sum_out) == '0)); // R5

    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> flags_out[3] == $past(size64 ? sum_out[DATA_W-1] : sum_out[HALF_W-1])); // R4

    AST_IMM_SHIFTED: assert property (@(posedge clk) disable iff (rst)
        (use_imm && imm_shift && size64) |-> sum_out == a_val + imm_up); // R1

endmodule

bind addflag_unit addflag_unit_chk #(
    .DATA_W   (DATA_W),
    .IMM_W    (IMM_W),
    .IMM_SHIFT(IMM_SHIFT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .size64   (size64),
    .use_imm  (use_imm),
    .imm_field(imm_field),
    .imm_shift(imm_shift),
    .a_val    (a_val),
    .set_flags(set_flags),
    .sum_out  (sum_out),
    .flags_out(flags_out)
);

// File: tb/addflag_unit_tb.sv
`timescale 1ns/1ps
module addflag_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        size64;
    logic        use_imm;
    logic [11:0] imm_field;
    logic        imm_shift;
    logic [63:0] a_val;
    logic [63:0] b_val;
    logic        set_flags;
    logic [63:0] sum_out;
    logic [3:0]  flags_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [63:0] sum;
        logic [3:0]  flags;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [3:0]  model_flags;

    always #2 clk = ~clk;

    addflag_unit u_dut (
        .clk(clk), .rst(rst), .size64(size64), .use_imm(use_imm),
        .imm_field(imm_field), .imm_shift(imm_shift), .a_val(a_val),
        .b_val(b_val), .set_flags(set_flags), .sum_out(sum_out),
        .flags_out(flags_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one operation and push its expected result.
    task automatic apply(input bit sz, input bit ui, input logic [11:0] imm,
                         input bit sh, input logic [63:0] a, input logic [63:0] b,
                         input bit sf, input string tag);
        exp_t        e;
        logic [63:0] mask, ua, ub, res;
        logic [64:0] full;
        int          w;
        logic [3:0]  f;
        @(negedge clk);
        size64 = sz; use_imm = ui; imm_field = imm; imm_shift = sh;
        a_val = a; b_val = b; set_flags = sf;
        w    = sz ? 64 : 32;
        mask = sz ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        ub   = ui ? (sh ? {52'd0, imm} * 64'd4096 : {52'd0, imm}) : b;
        ua   = a & mask;
        ub   = ub & mask;
        full = {1'b0, ua} + {1'b0, ub};
        res  = full[63:0] & mask;
        f[3] = res[w-1];
        f[2] = (res == 64'd0);
        f[1] = (ub > (mask - ua));
        f[0] = (ua[w-1] == ub[w-1]) && (res[w-1] != ua[w-1]);
        if (sf) model_flags = f;
        e.sum = res; e.flags = model_flags; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " sum"}, sum_out, e.sum);
                check({e.tag, " flags"}, {60'd0, flags_out}, {60'd0, e.flags});
            end
        end
    end

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic reset_phase();
        @(negedge clk);
        rst = 1'b1; size64 = 1'b1; use_imm = 1'b0; imm_field = '0; imm_shift = 1'b0;
        a_val = 64'h8000_0000_0000_0000; b_val = 64'h8000_0000_0000_0000; set_flags = 1'b1;
        @(posedge clk); #1;
        check("R9 reset clears flags despite set_flags", {60'd0, flags_out}, 64'd0);
        @(negedge clk);
        rst = 1'b0; set_flags = 1'b0;
        model_flags = 4'b0000;
    endtask

    initial begin
        rst = 1'b1; size64 = 0; use_imm = 0; imm_field = 0; imm_shift = 0;
        a_val = 0; b_val = 0; set_flags = 0; model_flags = 4'b0000;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset state", {60'd0, flags_out}, 64'd0);
        @(negedge clk); rst = 1'b0;

        apply(1, 0, 0, 0, 64'd1, 64'd2, 1, "R2 simple add");
        apply(1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, "R5 R6 wrap to zero");
        apply(1, 0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, "R4 R7 signed overflow");
        apply(1, 0, 0, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1, "R7 negative overflow");
        apply(0, 1, 12'd1, 0, 64'hDEAD_BEEF_FFFF_FFFF, 64'h0, 1, "R3 low-word wrap");
        apply(0, 0, 0, 0, 64'h1234_5678_7FFF_FFFF, 64'hAAAA_AAAA_0000_0001, 1, "R3 R7 32-bit overflow");
        apply(1, 1, 12'hABC, 1, 64'd5, 64'hFFFF, 1, "R1 shifted immediate");
        apply(1, 1, 12'hABC, 0, 64'd5, 64'hFFFF, 1, "R1 plain immediate");
        apply(0, 1, 12'hFFF, 1, 64'h0000_0000_FF00_0000, 64'd0, 1, "R1 R4 32-bit shifted imm");
        apply(1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, "R8 hold without set_flags");
        apply(0, 0, 0, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 0, "R8 hold 32-bit");
        apply(0, 0, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1, "R6 32-bit carry");
        drain();

        reset_phase();
        apply(1, 0, 0, 0, 64'd0, 64'd0, 0, "R9 flags stay clear after reset");
        apply(1, 0, 0, 0, 64'd0, 64'd0, 1, "R5 zero result");
        drain();

        for (int i = 0; i < 400; i++) begin
            apply($urandom_range(0, 1), $urandom_range(0, 1), 12'($urandom),
                  $urandom_range(0, 1), {$urandom, $urandom}, {$urandom, $urandom},
                  $urandom_range(0, 1), "R2 R3 R4 R5 R6 R7 R8 random");
        end
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule